// File: doc/BRIEF.md
# Pixel-Column Video Memory with Draw Decode

This block holds the picture for a small LED matrix as sixteen 16-bit words. Each word is one vertical column of the display, and each bit of a word is one pixel: 1 lights it, 0 leaves it dark. The processor fills the memory with a draw instruction, not with a plain write strobe. When the opcode of the current instruction decodes as the draw operation, the value read from the source register is stored into the column named by the instruction's destination field. Every other opcode leaves the picture as it is.

A display scanner has its own read port. It can fetch any column by index in the same cycle, with no effect on the write side. The whole 256-bit picture is also exposed as one flat vector for observation. A synchronous reset blanks the display.

Top module: `col_framebuf`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears all 16 columns to zero. After that edge `pic_flat` is all zeros and every scan read returns 0.
- R2: When `opcode` equals 19 (5'b10011) at a rising edge and `rst` is low, the column selected by `dst_field[3:0]` takes the value of `src_word`. Bit j of the stored column is exactly bit j of `src_word`, for any pattern including all ones and all zeros.
- R3: When `opcode` holds any of the other 31 values at a rising edge, no column changes.
- R4: On a draw, the fifteen columns that are not addressed keep their contents.
- R5: Bit 4 of `dst_field` is ignored. Destination values d and d+16 address the same column.
- R6: `scan_col` is combinational. In the same cycle it shows the stored column selected by `scan_idx`, for any index, whatever the write inputs are doing.
- R7: If the scan port reads the column that a draw is writing in the same cycle, it returns the old contents until the rising edge, and the new value after the edge.
- R8: Column k occupies bits [16k+15:16k] of `pic_flat`.
- R9: Reset takes priority over a draw presented at the same edge. The memory ends up all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high; blanks all columns |
| opcode | input | 5 | Opcode of the current instruction; value 19 is the draw operation |
| src_word | input | 16 | Source register value to store as one pixel column |
| dst_field | input | 5 | Destination operand; its low 4 bits select the column |
| scan_idx | input | 4 | Column index requested by the display scanner |
| scan_col | output | 16 | Combinational column read for the scanner |
| pic_flat | output | 256 | Whole picture, column k at bits [16k+15:16k] |

## Verification
The draw path is first exercised by writing a different pattern to every column in turn, so that a misrouted index or a swapped slice of the flat view is caught. Then all 31 non-draw opcodes are applied with live data and destination values; this separates an exact opcode match from a partial decode that ignores some opcode bits. Destinations with bit 4 set and all-ones and all-zero words check the index truncation and the bit order. Scan reads aimed at the column being drawn in that cycle, and a reset that coincides with a draw, check the same-cycle ordering rules.

// File: rtl/fb_pkg.sv
package fb_pkg;

    parameter int unsigned FB_NUM_COLS = 16;
    parameter int unsigned FB_ROWS     = 16;
    parameter int unsigned FB_OPC_W    = 5;
    parameter int unsigned FB_DST_W    = 5;
    parameter int unsigned FB_DRAW_OPC = 19;

    localparam int unsigned FB_IDX_W = $clog2(FB_NUM_COLS);

    function automatic int unsigned fb_col_lsb(input int unsigned col, input int unsigned rows);
        return col * rows;
    endfunction

endpackage

// File: rtl/fb_draw_decode.sv
module fb_draw_decode #(
    parameter int unsigned OPC_W    = 5,
    parameter int unsigned DRAW_OPC = 19,
    parameter int unsigned DST_W    = 5,
    parameter int unsigned NUM_COLS = 16
) (
    input  logic [OPC_W-1:0]    opcode,
    input  logic [DST_W-1:0]    dst_field,
    output logic [NUM_COLS-1:0] col_sel
);
    localparam int unsigned IDX_W = $clog2(NUM_COLS);
    localparam logic [OPC_W-1:0] DRAW_CODE = OPC_W'(DRAW_OPC);

    logic             draw_hit;
    logic [IDX_W-1:0] dst_idx;

    assign draw_hit = (opcode == DRAW_CODE);
    assign dst_idx  = dst_field[IDX_W-1:0];

    for (genvar c = 0; c < NUM_COLS; c++) begin : g_sel
        assign col_sel[c] = draw_hit && (dst_idx == IDX_W'(c));
    end

endmodule

// File: rtl/fb_col_store.sv
module fb_col_store #(
    parameter int unsigned NUM_COLS = 16,
    parameter int unsigned ROWS     = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NUM_COLS-1:0]      col_sel,
    input  logic [ROWS-1:0]          wr_word,
    output logic [NUM_COLS*ROWS-1:0] flat
);
    typedef struct packed {
        logic [NUM_COLS-1:0][ROWS-1:0] cols;
    } store_t;

    store_t store_d, store_q;

    always_comb begin
        store_d = store_q;
        if (rst) begin
            store_d.cols = '0;
        end else begin
            for (int c = 0; c < NUM_COLS; c++) begin
                if (col_sel[c]) begin
                    store_d.cols[c] = wr_word;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        store_q <= store_d;
    end

    assign flat = store_q.cols;

endmodule

// File: rtl/fb_scan_mux.sv
module fb_scan_mux #(
    parameter int unsigned NUM_COLS = 16,
    parameter int unsigned ROWS     = 16
) (
    input  logic [NUM_COLS*ROWS-1:0]     flat,
    input  logic [$clog2(NUM_COLS)-1:0]  scan_idx,
    output logic [ROWS-1:0]              scan_col
);
    always_comb begin
        scan_col = '0;
        for (int c = 0; c < NUM_COLS; c++) begin
            if (scan_idx == $bits(scan_idx)'(c)) begin
                scan_col = flat[c*ROWS +: ROWS];
            end
        end
    end

endmodule

// File: rtl/col_framebuf.sv
module col_framebuf
    import fb_pkg::*;
#(
    parameter int unsigned NUM_COLS = FB_NUM_COLS,
    parameter int unsigned ROWS     = FB_ROWS,
    parameter int unsigned OPC_W    = FB_OPC_W,
    parameter int unsigned DST_W    = FB_DST_W,
    parameter int unsigned DRAW_OPC = FB_DRAW_OPC,
    localparam int unsigned IDX_W   = $clog2(NUM_COLS),
    localparam int unsigned FLAT_W  = NUM_COLS * ROWS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [OPC_W-1:0]  opcode,
    input  logic [ROWS-1:0]   src_word,
    input  logic [DST_W-1:0]  dst_field,
    input  logic [IDX_W-1:0]  scan_idx,
    output logic [ROWS-1:0]   scan_col,
    output logic [FLAT_W-1:0] pic_flat
);
    logic [NUM_COLS-1:0] col_sel;

    fb_draw_decode #(
        .OPC_W    (OPC_W),
        .DRAW_OPC (DRAW_OPC),
        .DST_W    (DST_W),
        .NUM_COLS (NUM_COLS)
    ) u_decode (
        .opcode    (opcode),
        .dst_field (dst_field),
        .col_sel   (col_sel)
    );

    fb_col_store #(
        .NUM_COLS (NUM_COLS),
        .ROWS     (ROWS)
    ) u_store (
        .clk     (clk),
        .rst     (rst),
        .col_sel (col_sel),
        .wr_word (src_word),
        .flat    (pic_flat)
    );

    fb_scan_mux #(
        .NUM_COLS (NUM_COLS),
        .ROWS     (ROWS)
    ) u_scan (
        .flat     (pic_flat),
        .scan_idx (scan_idx),
        .scan_col (scan_col)
    );

endmodule

// File: rtl/fb_checker.sv
module fb_checker #(
    parameter int unsigned NUM_COLS = 16,
    parameter int unsigned ROWS     = 16,
    parameter int unsigned OPC_W    = 5,
    parameter int unsigned DST_W    = 5,
    parameter int unsigned DRAW_OPC = 19,
    localparam int unsigned IDX_W   = $clog2(NUM_COLS),
    localparam int unsigned FLAT_W  = NUM_COLS * ROWS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [OPC_W-1:0]  opcode,
    input  logic [ROWS-1:0]   src_word,
    input  logic [DST_W-1:0]  dst_field,
    input  logic [IDX_W-1:0]  scan_idx,
    input  logic [ROWS-1:0]   scan_col,
    input  logic [FLAT_W-1:0] pic_flat
);
    logic              primed_q = 1'b0;
    logic              prev_rst_q;
    logic              prev_draw_q;
    logic [IDX_W-1:0]  prev_idx_q;
    logic [ROWS-1:0]   prev_src_q;
    logic [FLAT_W-1:0] prev_flat_q;
    logic [FLAT_W-1:0] keep_mask;

    always_ff @(posedge clk) begin
        primed_q    <= 1'b1;
        prev_rst_q  <= rst;
        prev_draw_q <= (opcode == OPC_W'(DRAW_OPC));
        prev_idx_q  <= dst_field[IDX_W-1:0];
        prev_src_q  <= src_word;
        prev_flat_q <= pic_flat;
    end

    always_comb begin
        keep_mask = '1;
        keep_mask[int'(prev_idx_q)*ROWS +: ROWS] = '0;
    end

    assert_reset_clears_R1: assert property (@(posedge clk)
        primed_q && prev_rst_q |-> pic_flat == '0);

    assert_reset_beats_draw_R9: assert property (@(posedge clk)
        primed_q && prev_rst_q && prev_draw_q |-> pic_flat == '0);

    // R5 is covered too: the index is taken from the low bits only
    assert_draw_writes_R2: assert property (@(posedge clk) disable iff (rst)
        primed_q && !prev_rst_q && prev_draw_q
        |-> pic_flat[int'(prev_idx_q)*ROWS +: ROWS] == prev_src_q);

    assert_other_opc_hold_R3: assert property (@(posedge clk) disable iff (rst)
        primed_q && !prev_rst_q && !prev_draw_q |-> pic_flat == prev_flat_q);

    assert_only_target_R4: assert property (@(posedge clk) disable iff (rst)
        primed_q && !prev_rst_q && prev_draw_q
        |-> ((pic_flat ^ prev_flat_q) & keep_mask) == '0);

    assert_scan_matches_R6: assert property (@(posedge clk) disable iff (rst)
        primed_q |-> scan_col == pic_flat[int'(scan_idx)*ROWS +: ROWS]);

endmodule

bind col_framebuf fb_checker #(
    .NUM_COLS (NUM_COLS),
    .ROWS     (ROWS),
    .OPC_W    (OPC_W),
    .DST_W    (DST_W),
    .DRAW_OPC (DRAW_OPC)
) u_fb_checker (
    .clk       (clk),
    .rst       (rst),
    .opcode    (opcode),
    .src_word  (src_word),
    .dst_field (dst_field),
    .scan_idx  (scan_idx),
    .scan_col  (scan_col),
    .pic_flat  (pic_flat)
);

// File: tb/col_framebuf_test.sv
`timescale 1ns/1ps
module col_framebuf_test;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [4:0]   opcode = 5'd0;
    logic [15:0]  src_word = 16'd0;
    logic [4:0]   dst_field = 5'd0;
    logic [3:0]   scan_idx = 4'd0;
    logic [15:0]  scan_col;
    logic [255:0] pic_flat;

    col_framebuf uut (
        .clk       (clk),
        .rst       (rst),
        .opcode    (opcode),
        .src_word  (src_word),
        .dst_field (dst_field),
        .scan_idx  (scan_idx),
        .scan_col  (scan_col),
        .pic_flat  (pic_flat)
    );

    always #2 clk = ~clk;

    logic [15:0] model [16];
    int    n_checks = 0;
    int    n_fails  = 0;
    bit    done     = 1'b0;
    string last_tag = "R1";

    function automatic logic [255:0] model_flat();
        logic [255:0] f;
        for (int c = 0; c < 16; c++) f[c*16 +: 16] = model[c];
        return f;
    endfunction

    task automatic check_flat(input string tag);
        n_checks++;
        if (pic_flat !== model_flat()) begin
            n_fails++;
            $display("FAIL %s: pic_flat got %h expected %h", tag, pic_flat, model_flat());
        end
    endtask

    // one instruction cycle: verify previous result, apply inputs, verify scan, clock
    task automatic step(input logic r, input logic [4:0] op, input logic [15:0] src,
                        input logic [4:0] dst, input logic [3:0] sidx, input string tag);
        string stag;
        @(negedge clk);
        check_flat(last_tag);
        rst = r; opcode = op; src_word = src; dst_field = dst; scan_idx = sidx;
        #1;
        stag = (op == 5'd19 && sidx == dst[3:0]) ? "R7" : "R6";
        n_checks++;
        if (scan_col !== model[sidx]) begin
            n_fails++;
            $display("FAIL %s: scan_col[%0d] got %h expected %h", stag, sidx, scan_col, model[sidx]);
        end
        @(posedge clk);
        if (r) begin
            for (int c = 0; c < 16; c++) model[c] = 16'd0;
        end else if (op == 5'd19) begin
            model[dst[3:0]] = src;
        end
        last_tag = tag;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 4);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: run did not end, got timeout expected completion");
        finish_run();
    end

    initial begin
        for (int c = 0; c < 16; c++) model[c] = 16'd0;
        @(posedge clk);
        @(posedge clk);
        // R1: blank after reset, checked at the first step
        step(1'b0, 5'd0, 16'h0000, 5'd0, 4'd5, "R1");

        // R2 / R8: distinct pattern into every column, scan a different column
        for (int c = 0; c < 16; c++) begin
            step(1'b0, 5'd19, 16'h1357 ^ (16'(c) * 16'h1111), 5'(c), 4'(15 - c), "R2");
        end

        // R8: each column seen through the scan port equals its flat slice
        for (int c = 0; c < 16; c++) begin
            @(negedge clk);
            scan_idx = 4'(c);
            #1;
            n_checks++;
            if (scan_col !== pic_flat[c*16 +: 16] || scan_col !== model[c]) begin
                n_fails++;
                $display("FAIL R8: column %0d scan %h slice %h expected %h",
                         c, scan_col, pic_flat[c*16 +: 16], model[c]);
            end
        end

        // R3: every non-draw opcode with live data leaves the picture unchanged
        for (int op = 0; op < 32; op++) begin
            if (op != 19) begin
                step(1'b0, 5'(op), 16'hFFFF ^ 16'(op), 5'(op), 4'(op), "R3");
            end
        end

        // R4: single column rewritten, the rest compared via whole flat view
        step(1'b0, 5'd19, 16'hFFFF, 5'd7, 4'd6, "R4");
        step(1'b0, 5'd19, 16'h0000, 5'd0, 4'd1, "R4");

        // R5: destination bit 4 ignored
        step(1'b0, 5'd19, 16'hA5A5, 5'd18, 4'd2, "R5");
        step(1'b0, 5'd19, 16'h8001, 5'd31, 4'd15, "R5");

        // R7: scan the column being drawn in the same cycle, then after the edge
        step(1'b0, 5'd19, 16'h5A5A, 5'd9, 4'd9, "R7");
        step(1'b0, 5'd0, 16'h0000, 5'd0, 4'd9, "R7");
        step(1'b0, 5'd19, 16'hC3C3, 5'd25, 4'd9, "R7");
        step(1'b0, 5'd1, 16'h0000, 5'd0, 4'd9, "R7");

        // R9: reset together with a draw leaves everything blank
        step(1'b1, 5'd19, 16'hBEEF, 5'd3, 4'd3, "R9");
        step(1'b0, 5'd2, 16'h0000, 5'd0, 4'd3, "R1");
        step(1'b0, 5'd19, 16'h0F0F, 5'd12, 4'd12, "R2");
        @(negedge clk);
        check_flat(last_tag);
        finish_run();
    end

endmodule